// File: doc/BRIEF.md
# Looping Audio Channel Frame Counter

This block keeps the address and count state of one audio DMA channel. Software loads a base address for a circular buffer, a frame register holding the buffer size in 32-bit words minus one together with the current word index, and a sample register holding a reload count together with the current remaining count minus one. From this state the block presents the byte address the data mover should touch next. Each time the data mover offers a transfer, the block trims the request to whole samples and to the room left in the frame and in the sample countdown. It then advances the word index and the sub-word byte remainder, and counts the sample countdown down.

When a transfer consumes exactly the remaining sample bytes, the block raises a one-cycle expire pulse and reloads the countdown; this paces the channel interrupt. The sample width follows two format inputs, stereo and 16-bit. Each one that is set doubles the bytes per sample. A parameter removes the pause input for a record channel, which has no pause control.

Top module: `audio_chan_frame_ctr`

## Requirements
- R1: After reset the base address, both count registers and the byte remainder are zero, `expire` is low and `curAddr` is zero.
- R2: A register write with `regSel` 0 loads the base address. With `regSel` 1 it loads the frame register: bits 31:16 are the word index, bits 15:0 are the size in words minus one, and the byte remainder is cleared. With `regSel` 3 nothing changes.
- R3: A register write with `regSel` 2 loads only the reload count (bits 15:0 of `sampleCountOut`); the current count in bits 31:16 keeps its value.
- R4: `curAddr` equals the base address plus four times the word index plus the byte remainder.
- R5: Bytes per sample are 1 shifted left by (`fmtStereo` + `fmtWide`). The offered byte count is rounded down to a multiple of that. A transfer that rounds to zero changes nothing.
- R6: The bytes taken are the smallest of three values: the rounded request, the frame room, and the sample bytes left. The frame room is 4 × (size − index + 1) plus the remainder, or zero when the index exceeds the size. The sample bytes left are (current + 1) × bytes per sample.
- R7: When the bytes taken equal the sample bytes left, `expire` is high for exactly the next cycle and the current count reloads. Otherwise the current count becomes (sample bytes left − taken − 1) shifted right by the sample shift.
- R8: The word index grows by (taken + remainder) / 4, and the new remainder is (taken + remainder) mod 4.
- R9: With `loopSelN` low, the new word index is kept if it does not exceed the size and becomes 0 otherwise. With `loopSelN` high, the frame register is left unchanged by transfers, while the remainder still advances.
- R10: A transfer is ignored unless `chanEnable` is high and `chanPause` is low.
- R11: A register write in the same cycle as a transfer strobe wins, and the transfer is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 base, 1 frame, 2 sample, 3 none |
| regWrData | input | 32 | Register write data |
| fmtStereo | input | 1 | Two channels per sample |
| fmtWide | input | 1 | 16-bit samples |
| chanEnable | input | 1 | Channel enable |
| chanPause | input | 1 | Channel pause (unused in the record variant) |
| loopSelN | input | 1 | Low selects circular (loop) mode |
| xferDone | input | 1 | Transfer strobe from the data mover |
| xferBytes | input | 16 | Bytes offered by the data mover |
| curAddr | output | 32 | Next byte address |
| frameCountOut | output | 32 | Frame register {index, size} |
| sampleCountOut | output | 32 | Sample register {current, reload} |
| expire | output | 1 | One-cycle pulse when the sample countdown runs out |

## Verification
The hardest state to reach is a transfer whose size is set by the frame room rather than by the request or the countdown. Reaching it needs an odd byte remainder, an index at the end of the buffer, and a sample size that changes between transfers. The vector table reaches it by walking one buffer through mono 8-bit, mono 16-bit, stereo 16-bit and stereo 8-bit transfers in sequence. The last index is then left with only five bytes of room, and the index wraps. Directed steps afterwards reload the frame register at the final word. This checks the wrap and the expire in the same transfer, as well as the non-looping freeze.

// File: rtl/afc_pkg.sv
package afc_pkg;

  typedef enum logic [1:0] {
    SEL_BASE   = 2'd0,
    SEL_FRAME  = 2'd1,
    SEL_SAMPLE = 2'd2,
    SEL_NONE   = 2'd3
  } afc_sel_e;

  typedef struct packed {
    logic wrBase;
    logic wrFrame;
    logic wrSample;
    logic step;
  } afc_strobe_t;

endpackage

// File: rtl/afc_ctrl.sv
module afc_ctrl
  import afc_pkg::*;
#(
  parameter int BYTES_W   = 16,
  parameter bit HAS_PAUSE = 1'b1
) (
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic               chanEnable,
  input  logic               chanPause,
  input  logic               fmtStereo,
  input  logic               fmtWide,
  input  logic               xferDone,
  input  logic [BYTES_W-1:0] xferBytes,
  output afc_strobe_t        strobe,
  output logic [1:0]         shift,
  output logic [BYTES_W-1:0] reqBytes
);

  logic pauseEff;
  logic running;

  generate
    if (HAS_PAUSE) begin : g_pause
      assign pauseEff = chanPause;
    end else begin : g_nopause
      logic unusedPause;
      assign unusedPause = chanPause;
      assign pauseEff    = 1'b0;
    end
  endgenerate

  assign running = chanEnable & ~pauseEff;

  // sample shift: one step per format bit that widens a sample
  assign shift = {1'b0, fmtStereo} + {1'b0, fmtWide};

  // round the offer down to whole samples
  assign reqBytes = xferBytes & ~((BYTES_W'(1) << shift) - BYTES_W'(1));

  always_comb begin
    strobe          = '0;
    strobe.wrBase   = regWrEn && (afc_sel_e'(regSel) == SEL_BASE);
    strobe.wrFrame  = regWrEn && (afc_sel_e'(regSel) == SEL_FRAME);
    strobe.wrSample = regWrEn && (afc_sel_e'(regSel) == SEL_SAMPLE);
    // register writes take priority over a transfer
    strobe.step     = xferDone && running && (reqBytes != '0) && !regWrEn;
  end

endmodule

// File: rtl/afc_datapath.sv
module afc_datapath
  import afc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BYTES_W = 16,
  localparam int WORD_W = 2 * CNT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  afc_strobe_t        strobe,
  input  logic [WORD_W-1:0]  wrData,
  input  logic [1:0]         shift,
  input  logic [BYTES_W-1:0] reqBytes,
  input  logic               loopSelN,
  output logic [WORD_W-1:0]  curAddr,
  output logic [WORD_W-1:0]  frameCountOut,
  output logic [WORD_W-1:0]  sampleCountOut,
  output logic               expire
);

  localparam int WIDE = (BYTES_W > CNT_W) ? BYTES_W : CNT_W;
  localparam int W    = WIDE + 5;

  logic [WORD_W-1:0] frameBase;
  logic [CNT_W-1:0]  frameIdx;
  logic [CNT_W-1:0]  frameSize;
  logic [1:0]        leftover;
  logic [CNT_W-1:0]  reloadCnt;
  logic [CNT_W-1:0]  curCnt;

  logic [W-1:0] sampleBytes;
  logic [W-1:0] frameRoom;
  logic [W-1:0] reqW;
  logic [W-1:0] taken;
  logic [W-1:0] sum;
  logic [W-1:0] idxNext;
  logic         wrap;
  logic         hit;
  logic [CNT_W-1:0] curNext;

  always_comb begin
    sampleBytes = (W'(curCnt) + W'(1)) << shift;
    if (frameIdx > frameSize) frameRoom = '0;
    else frameRoom = ((W'(frameSize) - W'(frameIdx) + W'(1)) << 2) + W'(leftover);
    reqW  = W'(reqBytes);
    taken = reqW;
    if (frameRoom < taken)   taken = frameRoom;
    if (sampleBytes < taken) taken = sampleBytes;
    hit     = (taken == sampleBytes);
    sum     = taken + W'(leftover);
    idxNext = W'(frameIdx) + (sum >> 2);
    wrap    = idxNext > W'(frameSize);
    curNext = CNT_W'((sampleBytes - taken - W'(1)) >> shift);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameBase <= '0;
      frameIdx  <= '0;
      frameSize <= '0;
      leftover  <= '0;
      reloadCnt <= '0;
      curCnt    <= '0;
      expire    <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (strobe.wrBase) frameBase <= wrData;
      if (strobe.wrFrame) begin
        frameIdx  <= wrData[WORD_W-1:CNT_W];
        frameSize <= wrData[CNT_W-1:0];
        leftover  <= '0;
      end
      if (strobe.wrSample) reloadCnt <= wrData[CNT_W-1:0];
      if (strobe.step) begin
        leftover <= sum[1:0];
        expire   <= hit;
        curCnt   <= hit ? reloadCnt : curNext;
        if (!loopSelN) frameIdx <= wrap ? '0 : CNT_W'(idxNext);
      end
    end
  end

  assign curAddr        = frameBase + (WORD_W'(frameIdx) << 2) + WORD_W'(leftover);
  assign frameCountOut  = {frameIdx, frameSize};
  assign sampleCountOut = {curCnt, reloadCnt};

  // R7
  expire_after_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |-> $past(strobe.step));

  // R7
  expire_reloads_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |-> (curCnt == reloadCnt));

  // R9
  index_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !loopSelN) |=> (frameIdx <= frameSize));

  // R2
  frame_write_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrFrame |=> (leftover == 2'd0));

  // R3
  sample_write_keeps_cur_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrSample && !strobe.step) |=> $stable(curCnt));

endmodule

// File: rtl/audio_chan_frame_ctr.sv
module audio_chan_frame_ctr
  import afc_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BYTES_W   = 16,
  parameter bit HAS_PAUSE = 1'b1,
  localparam int WORD_W   = 2 * CNT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic [WORD_W-1:0]  regWrData,
  input  logic               fmtStereo,
  input  logic               fmtWide,
  input  logic               chanEnable,
  input  logic               chanPause,
  input  logic               loopSelN,
  input  logic               xferDone,
  input  logic [BYTES_W-1:0] xferBytes,
  output logic [WORD_W-1:0]  curAddr,
  output logic [WORD_W-1:0]  frameCountOut,
  output logic [WORD_W-1:0]  sampleCountOut,
  output logic               expire
);

  afc_strobe_t        strobe;
  logic [1:0]         shift;
  logic [BYTES_W-1:0] reqBytes;

  afc_ctrl #(.BYTES_W(BYTES_W), .HAS_PAUSE(HAS_PAUSE)) u_ctrl (
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .chanEnable(chanEnable),
    .chanPause (chanPause),
    .fmtStereo (fmtStereo),
    .fmtWide   (fmtWide),
    .xferDone  (xferDone),
    .xferBytes (xferBytes),
    .strobe    (strobe),
    .shift     (shift),
    .reqBytes  (reqBytes)
  );

  afc_datapath #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wrData        (regWrData),
    .shift         (shift),
    .reqBytes      (reqBytes),
    .loopSelN      (loopSelN),
    .curAddr       (curAddr),
    .frameCountOut (frameCountOut),
    .sampleCountOut(sampleCountOut),
    .expire        (expire)
  );

  // R10
  idle_channel_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && !chanEnable && !regWrEn) |=>
      ($stable(frameCountOut) && $stable(sampleCountOut) && $stable(curAddr)));

  // R5
  sub_sample_offer_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && !regWrEn && fmtStereo && fmtWide && (xferBytes < BYTES_W'(4))) |=>
      ($stable(frameCountOut) && $stable(sampleCountOut) && !expire));

  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd3) |=>
      ($stable(frameCountOut) && $stable(sampleCountOut) && $stable(curAddr) && !expire));

endmodule

// File: tb/tb_audio_chan_frame_ctr.sv
module tb_audio_chan_frame_ctr;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [1:0]  regSel;
  logic [31:0] regWrData;
  logic        fmtStereo, fmtWide, chanEnable, chanPause, loopSelN;
  logic        xferDone;
  logic [15:0] xferBytes;
  logic [31:0] curAddr, frameCountOut, sampleCountOut;
  logic        expire;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_chan_frame_ctr dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .fmtStereo(fmtStereo), .fmtWide(fmtWide),
    .chanEnable(chanEnable), .chanPause(chanPause), .loopSelN(loopSelN),
    .xferDone(xferDone), .xferBytes(xferBytes), .curAddr(curAddr),
    .frameCountOut(frameCountOut), .sampleCountOut(sampleCountOut),
    .expire(expire)
  );

  typedef struct packed {
    logic        st;
    logic        wd;
    logic [15:0] req;
    logic [15:0] idx;
    logic [15:0] cur;
    logic        exp;
    logic [31:0] addr;
  } vec_t;

  // buffer base 0x1000, size 3 (16 bytes), reload 3, loop mode
  localparam vec_t VEC [0:6] = '{
    '{1'b0, 1'b0, 16'd2,   16'd0, 16'd1, 1'b0, 32'h1003},
    '{1'b0, 1'b0, 16'd10,  16'd1, 16'd3, 1'b1, 32'h1005},
    '{1'b0, 1'b1, 16'd7,   16'd2, 16'd0, 1'b0, 32'h100B},
    '{1'b0, 1'b1, 16'd20,  16'd3, 16'd3, 1'b1, 32'h100D},
    '{1'b1, 1'b1, 16'd40,  16'd0, 16'd2, 1'b0, 32'h1002},
    '{1'b1, 1'b0, 16'd3,   16'd1, 16'd1, 1'b0, 32'h1004},
    '{1'b1, 1'b0, 16'd100, 16'd2, 16'd3, 1'b1, 32'h1008}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doXfer(input logic st, input logic wd, input logic [15:0] req);
    @(negedge clk);
    fmtStereo = st; fmtWide = wd; xferBytes = req; xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R1 actual=%h expected=%h", 32'd0, 32'd1);
    finish();
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regSel = 2'd3; regWrData = '0;
    fmtStereo = 1'b0; fmtWide = 1'b0; chanEnable = 1'b1; chanPause = 1'b0;
    loopSelN = 1'b0; xferDone = 1'b0; xferBytes = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 addr", curAddr, 32'h0);
    check("R1 frame", frameCountOut, 32'h0);
    check("R1 sample", sampleCountOut, 32'h0);
    check("R1 expire", {31'd0, expire}, 32'd0);

    // R2 R3 setup
    regWrite(2'd0, 32'h0000_1000);
    check("R2 base addr", curAddr, 32'h1000);
    regWrite(2'd1, 32'h0000_0003);
    check("R2 frame write", frameCountOut, 32'h0000_0003);
    regWrite(2'd2, 32'h0009_0003);
    check("R3 reload only", sampleCountOut, 32'h0000_0003);
    regWrite(2'd3, 32'hFFFF_FFFF);
    check("R2 select 3 ignored", frameCountOut ^ sampleCountOut ^ curAddr, 32'h0000_1000);

    // R7 first sample expires countdown of zero, R4 remainder in address
    doXfer(1'b0, 1'b0, 16'd5);
    check("R7 first expire", {31'd0, expire}, 32'd1);
    check("R7 reload", sampleCountOut, 32'h0003_0003);
    check("R4 addr", curAddr, 32'h1001);
    @(negedge clk);
    check("R7 pulse width", {31'd0, expire}, 32'd0);

    // R5 R6 R7 R8 R9 table walk
    for (int i = 0; i < 7; i++) begin
      doXfer(VEC[i].st, VEC[i].wd, VEC[i].req);
      check($sformatf("R8 R9 vec%0d frame", i), frameCountOut, {VEC[i].idx, 16'd3});
      check($sformatf("R6 R7 vec%0d sample", i), sampleCountOut, {VEC[i].cur, 16'd3});
      check($sformatf("R7 vec%0d expire", i), {31'd0, expire}, {31'd0, VEC[i].exp});
      check($sformatf("R4 R5 vec%0d addr", i), curAddr, VEC[i].addr);
    end

    // R2 frame write clears remainder
    doXfer(1'b0, 1'b0, 16'd1);
    check("R8 remainder", curAddr, 32'h1009);
    regWrite(2'd1, 32'h0001_0003);
    check("R2 remainder cleared", curAddr, 32'h1004);

    // R3 sample write keeps current half
    regWrite(2'd2, 32'hFFFF_0007);
    check("R3 current kept", sampleCountOut, 32'h0002_0007);

    // R10 disabled and paused
    chanEnable = 1'b0;
    doXfer(1'b0, 1'b0, 16'd4);
    check("R10 disabled addr", curAddr, 32'h1004);
    check("R10 disabled sample", sampleCountOut, 32'h0002_0007);
    chanEnable = 1'b1; chanPause = 1'b1;
    doXfer(1'b0, 1'b0, 16'd4);
    check("R10 paused sample", sampleCountOut, 32'h0002_0007);
    chanPause = 1'b0;

    // R5 offers that round to zero
    doXfer(1'b1, 1'b1, 16'd3);
    check("R5 rounds to zero", sampleCountOut, 32'h0002_0007);
    doXfer(1'b0, 1'b0, 16'd0);
    check("R5 zero offer", curAddr, 32'h1004);

    // R11 write and transfer in the same cycle
    @(negedge clk);
    regWrEn = 1'b1; regSel = 2'd3; regWrData = 32'h0;
    fmtStereo = 1'b0; fmtWide = 1'b0; xferBytes = 16'd4; xferDone = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; xferDone = 1'b0;
    check("R11 transfer dropped", sampleCountOut, 32'h0002_0007);

    // R9 non-loop mode freezes frame register
    loopSelN = 1'b1;
    doXfer(1'b0, 1'b0, 16'd2);
    check("R9 nonloop frame", frameCountOut, 32'h0001_0003);
    check("R9 nonloop addr", curAddr, 32'h1006);
    check("R7 nonloop sample", sampleCountOut, 32'h0000_0007);
    doXfer(1'b0, 1'b0, 16'd20);
    check("R7 nonloop expire", {31'd0, expire}, 32'd1);
    check("R9 nonloop addr2", curAddr, 32'h1007);
    loopSelN = 1'b0;

    // R9 index equal to size is kept
    regWrite(2'd1, 32'h0002_0003);
    doXfer(1'b0, 1'b0, 16'd4);
    check("R9 index at size", frameCountOut, 32'h0003_0003);
    check("R7 partial", sampleCountOut, 32'h0003_0007);
    check("R4 end addr", curAddr, 32'h100C);

    // R6 frame room limits, expire and wrap together
    doXfer(1'b0, 1'b0, 16'd100);
    check("R6 room clamp expire", {31'd0, expire}, 32'd1);
    check("R9 wrap", frameCountOut, 32'h0000_0003);
    check("R7 reload at wrap", sampleCountOut, 32'h0007_0007);

    // R2 new base moves address
    regWrite(2'd0, 32'h0000_2000);
    check("R2 new base", curAddr, 32'h2000);

    finish();
  end

endmodule